// File: doc/BRIEF.md
# Machine Interrupt Pending and Trap Entry Control

This block is the interrupt side of a machine-mode control-and-status unit in a small processor core. It watches three interrupt sources: a software-interrupt line, an external-interrupt line, and a timer whose pending state comes from comparing a free-running time count against a compare value. It holds the interrupt-enable, status and cause registers. It builds a read-only pending view from the live source levels.

When an enabled source is pending and the global enable is on, the block raises a take request to the fetch unit in the same cycle. It also gives the fetch unit the index of the chosen source as a vector select. On the next clock edge it performs trap entry in a single step:
- the cause register takes the interrupt flag and the index;
- the old global enable moves into the previous-enable bit;
- the global enable is cleared.

A return-from-trap strobe reverses the enable bookkeeping. Register access uses a two-bit select. Code 0 selects status, 1 selects enable, 2 selects pending and 3 selects cause. The read data is combinational, and a write strobe commits on the clock edge.

Top module: `mirq_trap_ctrl`

## Requirements
- R1: Pending bit 3 reads as the present level of the software-interrupt input, both when it is raised and when it is dropped.
- R2: Pending bit 7 is 1 exactly when the unsigned time value is greater than or equal to the compare value, over the full time width. A compare value of zero therefore keeps it set.
- R3: Pending bit 11 reads as the level of the external-interrupt input. Writes to the pending register (select code 2) change no pending bit.
- R4: The take request is high in the same cycle that some source has both its pending bit and its enable bit set while status bit 3 (global enable) is 1. Otherwise it is low.
- R5: With the global enable set and a source pending but its enable bit clear, no take request is raised, and the pending bit still reads 1.
- R6: On trap entry, the cause register becomes bit 31 set plus the serviced pending-bit index in the low bits. Software gives 0x80000003, timer gives 0x80000007 and external gives 0x8000000B.
- R7: On trap entry, status bit 7 takes the old bit 3, bit 3 clears, and bits 12:11 read 3. An entry from an enabled state leaves status at 0x00001880, and the take request drops in the following cycle.
- R8: A return-from-trap strobe copies status bit 7 into bit 3 and sets bit 7 to 1.
- R9: Among enabled pending sources, external wins over software and software wins over timer. The vector select output gives the winner's index.
- R10: After reset, status reads 0x00001800, and enable and cause read 0.
- R11: Only enable bits 3, 7 and 11 are writable. Only status bits 3 and 7 are writable, and status bits 12:11 always read 3. The cause register is writable in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_irq_i | input | 1 | Software-interrupt level |
| ext_irq_i | input | 1 | External-interrupt level |
| time_i | input | TIME_W | Current time count |
| time_cmp_i | input | TIME_W | Timer compare value |
| csr_sel_i | input | 2 | Register select: 0 status, 1 enable, 2 pending, 3 cause |
| csr_wen_i | input | 1 | Write strobe for the selected register |
| csr_wdata_i | input | XLEN | Write data |
| csr_rdata_o | output | XLEN | Read data of the selected register |
| trap_ret_i | input | 1 | Return-from-trap strobe |
| irq_take_o | output | 1 | Take-interrupt request to fetch |
| irq_vec_o | output | $clog2(XLEN) | Index of the interrupt being taken |

## Verification
The bench builds the block with its defaults, XLEN of 32 and a 64-bit time. This lets the expected status and cause words be written as the exact 32-bit values given in the requirements. It also lets the time comparison be exercised across the boundary between the two 32-bit halves, where a comparator cut to the low word would give the wrong answer. Priority is covered by walking down through all three sources: each is serviced, released and returned from in turn.

// File: rtl/mirq_pkg.sv
package mirq_pkg;

  typedef enum logic [1:0] {
    SEL_STATUS  = 2'd0,
    SEL_ENABLE  = 2'd1,
    SEL_PENDING = 2'd2,
    SEL_CAUSE   = 2'd3
  } csr_sel_e;

  // pending / enable bit positions
  localparam int IDX_SW  = 3;
  localparam int IDX_TMR = 7;
  localparam int IDX_EXT = 11;

  // status bit positions
  localparam int ST_GIE   = 3;
  localparam int ST_PGIE  = 7;
  localparam int ST_PPRV0 = 11;
  localparam int ST_PPRV1 = 12;

  // sources listed from highest to lowest priority
  localparam int NSRC = 3;
  localparam int SRC_IDX [NSRC] = '{IDX_EXT, IDX_SW, IDX_TMR};

endpackage

// File: rtl/mirq_pending.sv
module mirq_pending
  import mirq_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int TIME_W = 64
) (
  input  logic              sw_irq,
  input  logic              ext_irq,
  input  logic [TIME_W-1:0] now,
  input  logic [TIME_W-1:0] cmp,
  output logic [XLEN-1:0]   pend,
  output logic              tmr_hit
);

  function automatic logic time_reached(input logic [TIME_W-1:0] t,
                                        input logic [TIME_W-1:0] c);
    return t >= c;
  endfunction

  logic [NSRC-1:0] line;

  assign tmr_hit = time_reached(now, cmp);
  assign line    = {ext_irq, sw_irq, tmr_hit};

  always_comb begin
    pend = '0;
    for (int i = 0; i < NSRC; i++) begin
      pend[SRC_IDX[i]] = line[NSRC-1-i];
    end
  end

endmodule

// File: rtl/mirq_arbiter.sv
module mirq_arbiter
  import mirq_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int IDXW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] pend,
  input  logic [XLEN-1:0] enable,
  input  logic            gie,
  output logic [NSRC-1:0] req,
  output logic [NSRC-1:0] grant,
  output logic            take,
  output logic [IDXW-1:0] idx
);

  logic [NSRC:0]   above;
  logic [IDXW-1:0] idx_part [NSRC];

  assign above[0] = 1'b0;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign req[g]       = pend[SRC_IDX[g]] & enable[SRC_IDX[g]];
    assign grant[g]     = req[g] & ~above[g];
    assign above[g+1]   = above[g] | req[g];
    assign idx_part[g]  = grant[g] ? IDXW'(SRC_IDX[g]) : '0;
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < NSRC; i++) idx = idx | idx_part[i];
  end

  assign take = gie & above[NSRC];

endmodule

// File: rtl/mirq_csr_file.sv
module mirq_csr_file
  import mirq_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int IDXW = $clog2(XLEN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      sel,
  input  logic            wen,
  input  logic [XLEN-1:0] wdata,
  input  logic [XLEN-1:0] pend,
  input  logic            take,
  input  logic [IDXW-1:0] take_idx,
  input  logic            ret,
  output logic [XLEN-1:0] rdata,
  output logic [XLEN-1:0] status_q,
  output logic [XLEN-1:0] enable_q,
  output logic [XLEN-1:0] cause_q,
  output logic            gie
);

  function automatic logic [XLEN-1:0] enable_mask();
    logic [XLEN-1:0] m;
    m = '0;
    for (int i = 0; i < NSRC; i++) m[SRC_IDX[i]] = 1'b1;
    return m;
  endfunction

  function automatic logic [XLEN-1:0] make_cause(input logic [IDXW-1:0] i);
    logic [XLEN-1:0] c;
    c = XLEN'(i);
    c[XLEN-1] = 1'b1;
    return c;
  endfunction

  localparam logic [XLEN-1:0] EN_MASK = enable_mask();

  logic gie_q, pgie_q;
  logic wr_status, wr_enable, wr_cause;

  assign wr_status = wen && (csr_sel_e'(sel) == SEL_STATUS);
  assign wr_enable = wen && (csr_sel_e'(sel) == SEL_ENABLE);
  assign wr_cause  = wen && (csr_sel_e'(sel) == SEL_CAUSE);

  // trap entry outranks a same-cycle return or write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q  <= 1'b0;
      pgie_q <= 1'b0;
    end else if (take) begin
      pgie_q <= gie_q;
      gie_q  <= 1'b0;
    end else if (ret) begin
      gie_q  <= pgie_q;
      pgie_q <= 1'b1;
    end else if (wr_status) begin
      gie_q  <= wdata[ST_GIE];
      pgie_q <= wdata[ST_PGIE];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= '0;
    else if (take) cause_q <= make_cause(take_idx);
    else if (wr_cause) cause_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) enable_q <= '0;
    else if (wr_enable) enable_q <= wdata & EN_MASK;
  end

  always_comb begin
    status_q = '0;
    status_q[ST_GIE]   = gie_q;
    status_q[ST_PGIE]  = pgie_q;
    status_q[ST_PPRV0] = 1'b1;
    status_q[ST_PPRV1] = 1'b1;
  end

  assign gie = gie_q;

  always_comb begin
    unique case (csr_sel_e'(sel))
      SEL_STATUS:  rdata = status_q;
      SEL_ENABLE:  rdata = enable_q;
      SEL_PENDING: rdata = pend;
      SEL_CAUSE:   rdata = cause_q;
      default:     rdata = '0;
    endcase
  end

endmodule

// File: rtl/mirq_trap_ctrl.sv
module mirq_trap_ctrl
  import mirq_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int TIME_W = 64,
  localparam int IDXW  = $clog2(XLEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_irq_i,
  input  logic              ext_irq_i,
  input  logic [TIME_W-1:0] time_i,
  input  logic [TIME_W-1:0] time_cmp_i,
  input  logic [1:0]        csr_sel_i,
  input  logic              csr_wen_i,
  input  logic [XLEN-1:0]   csr_wdata_i,
  output logic [XLEN-1:0]   csr_rdata_o,
  input  logic              trap_ret_i,
  output logic              irq_take_o,
  output logic [IDXW-1:0]   irq_vec_o
);

  logic [XLEN-1:0] pend;
  logic            tmr_hit;
  logic [XLEN-1:0] status_q, enable_q, cause_q;
  logic            gie;
  logic [NSRC-1:0] req, grant;
  logic            take;
  logic [IDXW-1:0] take_idx;

  mirq_pending #(.XLEN(XLEN), .TIME_W(TIME_W)) u_pend (
    .sw_irq (sw_irq_i),
    .ext_irq(ext_irq_i),
    .now    (time_i),
    .cmp    (time_cmp_i),
    .pend   (pend),
    .tmr_hit(tmr_hit)
  );

  mirq_arbiter #(.XLEN(XLEN)) u_arb (
    .pend  (pend),
    .enable(enable_q),
    .gie   (gie),
    .req   (req),
    .grant (grant),
    .take  (take),
    .idx   (take_idx)
  );

  mirq_csr_file #(.XLEN(XLEN)) u_csr (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (csr_sel_i),
    .wen     (csr_wen_i),
    .wdata   (csr_wdata_i),
    .pend    (pend),
    .take    (take),
    .take_idx(take_idx),
    .ret     (trap_ret_i),
    .rdata   (csr_rdata_o),
    .status_q(status_q),
    .enable_q(enable_q),
    .cause_q (cause_q),
    .gie     (gie)
  );

  assign irq_take_o = take;
  assign irq_vec_o  = take_idx;

endmodule

// File: rtl/mirq_trap_chk.sv
module mirq_trap_chk
  import mirq_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sw_irq_i,
  input logic [1:0]      csr_sel_i,
  input logic [XLEN-1:0] csr_rdata_o,
  input logic            trap_ret_i,
  input logic            irq_take_o,
  input logic [XLEN-1:0] status_q,
  input logic [XLEN-1:0] cause_q,
  input logic [NSRC-1:0] grant
);

  AST_SW_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_sel_i == 2'd2) |-> (csr_rdata_o[IDX_SW] == sw_irq_i)); // R1

  AST_TAKE_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take_o |-> status_q[ST_GIE]); // R4

  AST_ENTRY_CAUSE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take_o |=> cause_q[XLEN-1]); // R6

  AST_ENTRY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take_o |=> (!status_q[ST_GIE] && status_q[ST_PGIE] && !irq_take_o)); // R7

  AST_RET_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_ret_i && !irq_take_o) |=> (status_q[ST_PGIE] &&
      (status_q[ST_GIE] == $past(status_q[ST_PGIE])))); // R8

  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R9

endmodule

bind mirq_trap_ctrl mirq_trap_chk #(.XLEN(XLEN)) u_trap_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sw_irq_i   (sw_irq_i),
  .csr_sel_i  (csr_sel_i),
  .csr_rdata_o(csr_rdata_o),
  .trap_ret_i (trap_ret_i),
  .irq_take_o (irq_take_o),
  .status_q   (status_q),
  .cause_q    (cause_q),
  .grant      (grant)
);

// File: tb/mirq_trap_ctrl_test.sv
`timescale 1ns/1ps
module mirq_trap_ctrl_test;

  localparam int XLEN = 32;
  localparam int TIME_W = 64;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              sw_irq_i = 1'b0;
  logic              ext_irq_i = 1'b0;
  logic [TIME_W-1:0] time_i = '0;
  logic [TIME_W-1:0] time_cmp_i = '1;
  logic [1:0]        csr_sel_i = 2'd0;
  logic              csr_wen_i = 1'b0;
  logic [XLEN-1:0]   csr_wdata_i = '0;
  logic [XLEN-1:0]   csr_rdata_o;
  logic              trap_ret_i = 1'b0;
  logic              irq_take_o;
  logic [4:0]        irq_vec_o;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  mirq_trap_ctrl #(.XLEN(XLEN), .TIME_W(TIME_W)) uut (
    .clk(clk), .rst_n(rst_n), .sw_irq_i(sw_irq_i), .ext_irq_i(ext_irq_i),
    .time_i(time_i), .time_cmp_i(time_cmp_i), .csr_sel_i(csr_sel_i),
    .csr_wen_i(csr_wen_i), .csr_wdata_i(csr_wdata_i), .csr_rdata_o(csr_rdata_o),
    .trap_ret_i(trap_ret_i), .irq_take_o(irq_take_o), .irq_vec_o(irq_vec_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] v);
    csr_sel_i = sel;
    #1;
    v = csr_rdata_o;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    csr_sel_i = sel; csr_wdata_i = d; csr_wen_i = 1'b1;
    tick();
    csr_wen_i = 1'b0;
  endtask

  task automatic ret_pulse();
    trap_ret_i = 1'b1;
    tick();
    trap_ret_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(2'd0, v); check("R10 status", v, 32'h1800);
    rd(2'd1, v); check("R10 enable", v, 0);
    rd(2'd3, v); check("R10 cause", v, 0);
    check("R10 take", irq_take_o, 0);
  endtask

  task automatic t_pending();
    logic [31:0] v;
    sw_irq_i = 1; rd(2'd2, v); check("R1 sw up", v, 32'h8);
    sw_irq_i = 0; rd(2'd2, v); check("R1 sw down", v, 0);
    time_i = 5; time_cmp_i = 10; rd(2'd2, v); check("R2 below", v, 0);
    time_i = 10; rd(2'd2, v); check("R2 equal", v, 32'h80);
    time_i = 0; time_cmp_i = 0; rd(2'd2, v); check("R2 cmp zero", v, 32'h80);
    time_i = 64'h1_0000_0000; time_cmp_i = 64'hFFFF_FFFF; rd(2'd2, v);
    check("R2 high word", v, 32'h80);
    time_i = 64'h0_FFFF_FFFF; time_cmp_i = 64'h1_0000_0000; rd(2'd2, v);
    check("R2 high word below", v, 0);
    ext_irq_i = 1; rd(2'd2, v); check("R3 ext", v, 32'h800);
    wr(2'd2, 32'h0); rd(2'd2, v); check("R3 write clear ignored", v, 32'h800);
    ext_irq_i = 0;
    wr(2'd2, 32'hFFFF_FFFF); rd(2'd2, v); check("R3 write set ignored", v, 0);
  endtask

  task automatic t_masks();
    logic [31:0] v;
    wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, v); check("R11 enable mask", v, 32'h888);
    wr(2'd1, 0);
    wr(2'd0, 32'hFFFF_FF77); rd(2'd0, v); check("R11 status mask", v, 32'h1800);
    wr(2'd3, 32'h1234_5678); rd(2'd3, v); check("R11 cause write", v, 32'h1234_5678);
    wr(2'd3, 0);
  endtask

  task automatic t_gate();
    logic [31:0] v;
    wr(2'd0, 32'h8);
    sw_irq_i = 1; #1;
    check("R5 no take with enable clear", irq_take_o, 0);
    rd(2'd2, v); check("R5 pending still set", v, 32'h8);
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h8); #1;
    check("R4 no take with global clear", irq_take_o, 0);
    sw_irq_i = 0; #1;
  endtask

  task automatic t_entry();
    logic [31:0] v;
    wr(2'd1, 32'h8);
    sw_irq_i = 1;
    wr(2'd0, 32'h8); // global on at this edge; take comb now
    check("R4 take raised", irq_take_o, 1);
    check("R9 vec sw", irq_vec_o, 3);
    tick();
    rd(2'd3, v); check("R6 cause sw", v, 32'h8000_0003);
    rd(2'd0, v); check("R7 status after entry", v, 32'h1880);
    check("R7 take drops", irq_take_o, 0);
    sw_irq_i = 0;
    ret_pulse();
    rd(2'd0, v); check("R8 status after return", v, 32'h1888);
    wr(2'd0, 32'h0);
    ret_pulse();
    rd(2'd0, v); check("R8 return with prev clear", v, 32'h1880);
    wr(2'd0, 32'h0);
  endtask

  task automatic t_priority();
    logic [31:0] v;
    wr(2'd1, 32'h888);
    sw_irq_i = 1; ext_irq_i = 1; time_i = 0; time_cmp_i = 0;
    wr(2'd0, 32'h8);
    check("R9 vec ext first", irq_vec_o, 11);
    tick();
    rd(2'd3, v); check("R9 cause ext", v, 32'h8000_000B);
    ext_irq_i = 0;
    ret_pulse();
    check("R9 vec sw over timer", irq_vec_o, 3);
    tick();
    rd(2'd3, v); check("R9 cause sw", v, 32'h8000_0003);
    sw_irq_i = 0;
    ret_pulse();
    check("R9 vec timer", irq_vec_o, 7);
    tick();
    rd(2'd3, v); check("R6 cause timer", v, 32'h8000_0007);
    time_cmp_i = '1;
    ret_pulse();
    check("R4 idle after all released", irq_take_o, 0);
  endtask

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    tick();
    t_reset();
    t_pending();
    t_masks();
    t_gate();
    t_entry();
    t_priority();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule